// File: doc/BRIEF.md
# UART FIFO Interrupt Status Generator

This block produces the interrupt status of a UART that has a receive FIFO and a transmit FIFO. It does not hold any characters. It watches the occupancy count of each FIFO, the push and pop strobes of the receive FIFO, and a baud tick. From these it keeps three raw interrupt bits and two receive-FIFO flags. The raw bits are a receive-threshold bit, a transmit-space bit and a receive-timeout bit. The flags are empty and full. The raw bits are ANDed with a software mask, and the results are ORed into one interrupt line.

Both FIFOs use a fixed threshold of half their depth. The receive-timeout bit exists so that software learns about a few waiting characters without waiting for the receive FIFO to fill halfway. It can be raised in two ways:
- by an idle gap of a set number of baud ticks with no receive activity, or
- when the instant mode input is high, by each arriving character.

Either way, the timeout bit clears only when the receive FIFO drains to empty. A small register port reads the raw status, reads and writes the mask, and reads the masked status and the flags.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the raw bits are 0, the mask is 0, the empty flag is 1, the full flag is 0 and `irqOut` is 0.
- R2: One cycle after any cycle, raw bit 1 (transmit) is 1 exactly when `txLevel` in that cycle was at most DEPTH minus DEPTH/2.
- R3: A receive push that brings the occupancy to DEPTH/2 or more sets raw bit 0 (receive). A receive pop that leaves fewer than DEPTH minus DEPTH/2 entries clears it. Otherwise the bit holds.
- R4: A pop that leaves the receive FIFO empty sets the empty flag. A push that is accepted clears it.
- R5: An accepted push that brings the occupancy to DEPTH sets the full flag. Every `rxPop` pulse clears it, including a pop on an empty FIFO. A push while the FIFO is full is ignored.
- R6: While the receive FIFO holds data, raw bit 2 (timeout) sets on the IDLE_TICKS-th `baudTick` that arrives with no push or pop strobe in between. It stays 0 on the tick before that one.
- R7: Every push or pop strobe restarts the idle tick count from zero. A tick that arrives in the same cycle as a strobe is not counted.
- R8: When `instantMode` is 1, every accepted push sets raw bit 2 on the next edge. When `instantMode` is 0, a push alone does not set it.
- R9: Raw bit 2 clears only on a pop that leaves the receive FIFO empty. Pops that leave data in the FIFO keep it set.
- R10: The register read address selects what `regRdData` shows, zero-extended, through a combinational path:
  - address 0: the raw bits {timeout, transmit, receive};
  - address 1: the 3-bit mask;
  - address 2: the raw bits ANDed with the mask;
  - address 3: {full, empty}.
  A write with `regWrEn` to address 1 loads the mask from the low three data bits.
- R11: `irqOut` is the OR of the masked raw bits. It changes right after the same edge that changes a raw bit or the mask, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instantMode | input | 1 | 1: each arriving character raises the timeout bit |
| rxLevel | input | LVL_W | Receive FIFO occupancy before this cycle's strobes |
| txLevel | input | LVL_W | Transmit FIFO occupancy |
| rxPush | input | 1 | Character written into the receive FIFO |
| rxPop | input | 1 | Read attempt on the receive FIFO |
| baudTick | input | 1 | One pulse per baud period |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data |
| rawStatus | output | 3 | Raw bits {timeout, transmit, receive} |
| rxEmpty | output | 1 | Receive FIFO empty flag |
| rxFull | output | 1 | Receive FIFO full flag |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with DEPTH = 8 and IDLE_TICKS = 5 instead of 16 and 32. This lets one vector table fill the receive FIFO to full, push once more into the full FIFO, drain it past the half-way line and pop on empty, all in about twenty steps. The short idle window lets the directed tests place the timeout edge exactly:
- the tick before the threshold, checked to leave the bit clear;
- the threshold tick, checked to set the bit;
- a restart part-way through the window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int RAW_BITS = 3;
  localparam int BIT_RX   = 0;
  localparam int BIT_TX   = 1;
  localparam int BIT_RT   = 2;

  localparam logic [1:0] ADDR_RAW    = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_MASKED = 2'd2;
  localparam logic [1:0] ADDR_FLAGS  = 2'd3;

  typedef struct packed {
    logic setRx;
    logic clrRx;
    logic txOn;
    logic setRt;
    logic clrRt;
    logic setEmpty;
    logic clrEmpty;
    logic setFull;
    logic clrFull;
  } irqStrobes_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int IDLE_TICKS = 32,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instantMode,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             baudTick,
  output irqStrobes_t      strobes
);

  localparam int CNT_W = $clog2(IDLE_TICKS + 1);
  localparam logic [LVL_W-1:0] TRIG     = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] FREE_THR = LVL_W'(DEPTH - DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_TICKS - 1);

  logic             pushOk;
  logic             popOk;
  logic [LVL_W-1:0] rxNext;
  logic [CNT_W-1:0] idleCnt;
  logic             anyStrobe;
  logic             tickCounts;
  logic             timeoutHit;

  assign pushOk     = rxPush && (rxLevel < FULL_LVL);
  assign popOk      = rxPop && (rxLevel != '0);
  assign rxNext     = rxLevel + LVL_W'(pushOk) - LVL_W'(popOk);
  assign anyStrobe  = rxPush || rxPop;
  assign tickCounts = baudTick && !anyStrobe && (rxLevel != '0);
  assign timeoutHit = tickCounts && (idleCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (anyStrobe || (rxLevel == '0)) begin
      idleCnt <= '0;
    end else if (tickCounts && (idleCnt < CNT_MAX)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.setRx    = pushOk && (rxNext >= TRIG);
    strobes.clrRx    = popOk && (rxNext < FREE_THR);
    strobes.txOn     = (txLevel <= FREE_THR);
    strobes.setEmpty = popOk && (rxNext == '0);
    strobes.clrEmpty = pushOk;
    strobes.setFull  = pushOk && (rxNext == FULL_LVL);
    strobes.clrFull  = rxPop;
    strobes.clrRt    = popOk && (rxNext == '0);
    strobes.setRt    = (instantMode && pushOk) || timeoutHit;
  end

  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> (idleCnt == '0));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_MAX);

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobes_t         strobes,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic [RAW_BITS-1:0] rawVec,
  output logic                emptyFlag,
  output logic                fullFlag,
  output logic                irqOut
);

  logic                rawRx;
  logic                rawTx;
  logic                rawRt;
  logic [RAW_BITS-1:0] maskReg;
  logic [RAW_BITS-1:0] maskedVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawRx     <= 1'b0;
      rawTx     <= 1'b0;
      rawRt     <= 1'b0;
      emptyFlag <= 1'b1;
      fullFlag  <= 1'b0;
      maskReg   <= '0;
    end else begin
      rawTx <= strobes.txOn;

      if (strobes.setRx)      rawRx <= 1'b1;
      else if (strobes.clrRx) rawRx <= 1'b0;

      if (strobes.clrRt)      rawRt <= 1'b0;
      else if (strobes.setRt) rawRt <= 1'b1;

      if (strobes.setEmpty)      emptyFlag <= 1'b1;
      else if (strobes.clrEmpty) emptyFlag <= 1'b0;

      if (strobes.clrFull)      fullFlag <= 1'b0;
      else if (strobes.setFull) fullFlag <= 1'b1;

      if (regWrEn && (regAddr == ADDR_MASK)) maskReg <= regWrData[RAW_BITS-1:0];
    end
  end

  always_comb begin
    rawVec         = '0;
    rawVec[BIT_RX] = rawRx;
    rawVec[BIT_TX] = rawTx;
    rawVec[BIT_RT] = rawRt;
  end

  assign maskedVec = rawVec & maskReg;
  assign irqOut    = |maskedVec;

  always_comb begin
    case (regAddr)
      ADDR_RAW:    regRdData = REG_W'(rawVec);
      ADDR_MASK:   regRdData = REG_W'(maskReg);
      ADDR_MASKED: regRdData = REG_W'(maskedVec);
      default:     regRdData = REG_W'({fullFlag, emptyFlag});
    endcase
  end

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(emptyFlag && fullFlag));

  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == ADDR_MASK)) |=> (maskReg == $past(regWrData[RAW_BITS-1:0])));

  p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskReg != '0));

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int IDLE_TICKS = 32,
  parameter int REG_W      = 8,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instantMode,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             baudTick,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [2:0]       rawStatus,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             irqOut
);

  irqStrobes_t strobes;

  uart_irq_ctrl #(
    .DEPTH      (DEPTH),
    .IDLE_TICKS (IDLE_TICKS),
    .LVL_W      (LVL_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instantMode (instantMode),
    .rxLevel     (rxLevel),
    .txLevel     (txLevel),
    .rxPush      (rxPush),
    .rxPop       (rxPop),
    .baudTick    (baudTick),
    .strobes     (strobes)
  );

  uart_irq_dp #(
    .REG_W (REG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rawVec    (rawStatus),
    .emptyFlag (rxEmpty),
    .fullFlag  (rxFull),
    .irqOut    (irqOut)
  );

  p_rt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[BIT_RT] && !(rxPop && !rxPush && (rxLevel == LVL_W'(1))))
      |=> rawStatus[BIT_RT]);

  p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxFull);

  p_tx_space_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == '0) |=> rawStatus[BIT_TX]);

endmodule

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;

  localparam int DEPTH = 8;
  localparam int IDLE  = 5;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int RW    = 8;
  localparam int NVEC  = 19;

  // {push, pop, tick, txLevel[3:0], expRx, expTx, expEmpty, expFull, expRt}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b100_0000_01000, 12'b100_0100_01000, 12'b100_0101_00000,
    12'b100_1000_10000, 12'b101_0011_11000, 12'b100_0011_11000,
    12'b100_0011_11000, 12'b100_0011_11010, 12'b100_0011_11010,
    12'b011_0011_11000, 12'b110_0011_11000, 12'b010_0011_11000,
    12'b010_0011_11000, 12'b010_0011_11000, 12'b011_0011_01000,
    12'b010_0011_01000, 12'b010_0011_01000, 12'b010_0011_01100,
    12'b010_0011_01100
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instantMode = 1'b0;
  logic [LW-1:0] rxLevel = '0;
  logic [LW-1:0] txLevel = '0;
  logic          rxPush = 1'b0;
  logic          rxPop = 1'b0;
  logic          baudTick = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic          regWrEn = 1'b0;
  logic [RW-1:0] regWrData = '0;
  logic [RW-1:0] regRdData;
  logic [2:0]    rawStatus;
  logic          rxEmpty;
  logic          rxFull;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  int lvl = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_status #(.DEPTH(DEPTH), .IDLE_TICKS(IDLE), .REG_W(RW)) dut (
    .clk(clk), .rstN(rstN), .instantMode(instantMode), .rxLevel(rxLevel),
    .txLevel(txLevel), .rxPush(rxPush), .rxPop(rxPop), .baudTick(baudTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rawStatus(rawStatus), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit push, input bit pop, input bit tick);
    @(negedge clk);
    rxPush = push; rxPop = pop; baudTick = tick;
    @(posedge clk);
    #1;
    if (push && lvl < DEPTH) lvl++;
    if (pop && lvl > 0) lvl--;
    rxLevel = LW'(lvl);
    rxPush = 1'b0; rxPop = 1'b0; baudTick = 1'b0;
  endtask

  task automatic wrMask(input logic [2:0] m);
    @(negedge clk);
    regAddr = 2'd1; regWrEn = 1'b1; regWrData = RW'(m);
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk("R1 raw", int'(rawStatus), 0);
    chk("R1 empty", int'(rxEmpty), 1);
    chk("R1 full", int'(rxFull), 0);
    chk("R1 irq", int'(irqOut), 0);
    rdReg(2'd1, v); chk("R1 mask", v, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      txLevel = VEC[i][8:5];
      step(VEC[i][11], VEC[i][10], VEC[i][9]);
      chk($sformatf("R3 rx row%0d", i), int'(rawStatus[0]), int'(VEC[i][4]));
      chk($sformatf("R2 tx row%0d", i), int'(rawStatus[1]), int'(VEC[i][3]));
      chk($sformatf("R4 empty row%0d", i), int'(rxEmpty), int'(VEC[i][2]));
      chk($sformatf("R5 full row%0d", i), int'(rxFull), int'(VEC[i][1]));
      chk($sformatf("R7 rt row%0d", i), int'(rawStatus[2]), int'(VEC[i][0]));
    end

    // R6 idle timeout
    step(1, 0, 0);
    for (int k = 0; k < IDLE - 1; k++) step(0, 0, 1);
    chk("R6 before threshold", int'(rawStatus[2]), 0);
    step(0, 0, 1);
    chk("R6 at threshold", int'(rawStatus[2]), 1);

    // R9 sticky until drained
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R9 held with data", int'(rawStatus[2]), 1);
    step(0, 1, 0);
    chk("R9 cleared on empty", int'(rawStatus[2]), 0);
    chk("R4 empty after drain", int'(rxEmpty), 1);

    // R7 restart
    step(1, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 1);
    step(1, 0, 0);
    for (int k = 0; k < IDLE - 1; k++) step(0, 0, 1);
    chk("R7 restarted count", int'(rawStatus[2]), 0);
    step(0, 0, 1);
    chk("R7 hit after restart", int'(rawStatus[2]), 1);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R9 drained", int'(rawStatus[2]), 0);

    // R8 instant mode
    instantMode = 1'b1;
    step(1, 0, 0);
    chk("R8 instant push", int'(rawStatus[2]), 1);
    step(0, 1, 0);
    chk("R8 cleared", int'(rawStatus[2]), 0);
    instantMode = 1'b0;
    step(1, 0, 0);
    chk("R8 mode off", int'(rawStatus[2]), 0);
    step(0, 1, 0);

    // R10 R11 registers and combined line
    txLevel = '0;
    step(0, 0, 0);
    wrMask(3'b010);
    chk("R11 irq with tx mask", int'(irqOut), 1);
    rdReg(2'd1, v); chk("R10 mask read", v, 2);
    rdReg(2'd0, v); chk("R10 raw read", v, 2);
    rdReg(2'd2, v); chk("R10 masked read", v, 2);
    rdReg(2'd3, v); chk("R10 flags read", v, 1);
    wrMask(3'b001);
    chk("R11 irq off after mask", int'(irqOut), 0);
    for (int k = 0; k < DEPTH / 2 - 1; k++) step(1, 0, 0);
    chk("R11 irq below trigger", int'(irqOut), 0);
    step(1, 0, 0);
    chk("R11 irq same edge as rx", int'(irqOut), 1);
    rdReg(2'd2, v); chk("R10 masked rx", v, 1);
    wrMask(3'b000);
    chk("R11 irq mask cleared", int'(irqOut), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule